// File: doc/BRIEF.md
# DMA Transfer Byte Counter

This block keeps track of how many bytes remain in a DMA transfer. Software programs a 24-bit start count through three byte-wide register locations on a simple register bus. Each time a DMA command is issued, the start count is copied into a current count, and the current count is read back through the same three locations. Every transfer strobe lowers the current count by one for a byte or by two for a 16-bit word. When the count reaches zero, a terminal-count status bit is raised.

The strobe that counts depends on the device role and on the bus phase. In the target role, the DMA acknowledge counts during data-in and the request strobe counts during data-out. In the initiator role, the DMA acknowledge counts during synchronous data-in and during data-out, and the handshake acknowledge counts during asynchronous data-in. Every strobe comes from outside the clock domain, so it is synchronized and counted on its rising edge.

The upper count byte can be used only while a wide-count enable is high; with the enable low, the counter works as a 16-bit counter. The start count has no reset, so the same transfer size can be reused after a reset. Until the upper start byte is first written after reset, reading its location returns a fixed identification code.

Top module: `xfer_count_unit`

## Requirements
- R1: A write to address 0x0, 0x1 or 0xE sets start-count bits 7:0, 15:8 or 23:16. A read (`reg_rd` high) of the same address returns the same byte of the current count on `reg_rdata` in that cycle, and `reg_rdata` is zero when `reg_rd` is low.
- R2: While `wide_en` is 0, a write to 0xE is ignored, a read of 0xE returns 0x00 once the identification code is gone, and a load uses only start bits 15:0. While `wide_en` is 1, all 24 bits are used.
- R3: A pulse on `cmd_dma_load` copies the start count into the current count. A start value of zero loads the maximum count: 2^24 in wide mode and 2^16 in narrow mode. A count of 2^24 reads as zero in all three bytes.
- R4: A counted strobe lowers the count by 1 when `word_xfer` is 0 and by 2 when it is 1. The count saturates at zero and never wraps, and a strobe at a count of zero has no effect.
- R5: `term_count` rises in the cycle after a strobe brings a nonzero count to zero. It stays high until a `status_rd` pulse or a load clears it, and it is 0 after reset.
- R6: The start count is not affected by `rst_n`. A load after reset restores the previously written value. The current count resets to zero.
- R7: After reset, a read of 0xE returns the identification code (default 0xA5) until the first accepted write to 0xE.
- R8: A `cmd_dma_nop` pulse arms count writes until the next load command or reset. A write to a count address while not armed is dropped and sets `wr_err`, which stays high until reset.
- R9: `xfer_phase` is encoded as 0 = synchronous data-in, 1 = asynchronous data-in, 2 = data-out, 3 = idle, and `role_target` = 1 selects the target role. The counted strobe is chosen as follows, and all other strobes are ignored:
  - target role, either data-in phase: `dack_in`
  - target role, data-out: `req_in`
  - initiator role, synchronous data-in: `dack_in`
  - initiator role, asynchronous data-in: `ack_in`
  - initiator role, data-out: `dack_in`
- R10: Each low-to-high transition of the selected strobe counts exactly once, however long the strobe stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte (combinational) |
| wide_en | input | 1 | Enables the upper count byte |
| cmd_dma_nop | input | 1 | DMA no-operation command pulse |
| cmd_dma_load | input | 1 | DMA command pulse; loads the counter |
| role_target | input | 1 | 1 = target role, 0 = initiator role |
| xfer_phase | input | 2 | Bus phase code |
| word_xfer | input | 1 | 1 = each strobe moves a 16-bit word |
| dack_in | input | 1 | DMA acknowledge strobe (asynchronous) |
| req_in | input | 1 | Bus request strobe (asynchronous) |
| ack_in | input | 1 | Bus acknowledge strobe (asynchronous) |
| status_rd | input | 1 | Status read pulse; clears terminal count |
| term_count | output | 1 | Terminal-count status bit |
| wr_err | output | 1 | Sticky flag for a dropped write |

## Verification
The bench steps one known count through every role and phase combination and also pulses the strobes that should be ignored. A design with a swapped selection table would count a strobe it should not, and the count read back would be one too low. The bench brings a count of one to zero with a word strobe and then strobes again at zero. A design without saturation would wrap to all ones or miss the terminal-count flag. It loads a zero start value in both widths, where a design without the maximum-count rule would end at zero after a single strobe instead of at all ones. It also checks that the identification code survives reset, that a write without a prior no-operation command is dropped, and that the start value is still present after reset. Any of these mistakes shows up as a wrong byte on the read bus.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 3;
  localparam int CNT_W     = BYTE_W * NUM_BYTES;
  localparam int NARROW_W  = 2 * BYTE_W;

  localparam logic [3:0] ADDR_LO  = 4'h0;
  localparam logic [3:0] ADDR_MID = 4'h1;
  localparam logic [3:0] ADDR_HI  = 4'hE;

  localparam int STB_DACK = 0;
  localparam int STB_REQ  = 1;
  localparam int STB_ACK  = 2;
  localparam int NUM_STB  = 3;

  typedef enum logic [1:0] {
    PH_DIN_SYNC  = 2'd0,
    PH_DIN_ASYNC = 2'd1,
    PH_DOUT      = 2'd2,
    PH_IDLE      = 2'd3
  } xfer_phase_e;
endpackage

// File: rtl/xfer_strobe_sel.sv
module xfer_strobe_sel
  import xfer_count_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        role_target_i,
  input  xfer_phase_e phase_i,
  input  logic        dack_i,
  input  logic        req_i,
  input  logic        ack_i,
  output logic        dec_pulse_o
);
  logic [NUM_STB-1:0] raw_w;
  logic [NUM_STB-1:0] edge_w;
  logic [NUM_STB-1:0] sel_w;

  assign raw_w[STB_DACK] = dack_i;
  assign raw_w[STB_REQ]  = req_i;
  assign raw_w[STB_ACK]  = ack_i;

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic                   prev_q, prev_d;

    always_comb begin
      sync_d = {sync_q[SYNC_STAGES-2:0], raw_w[g]};
      prev_d = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= sync_d;
        prev_q <= prev_d;
      end
    end

    assign edge_w[g] = sync_q[SYNC_STAGES-1] & ~prev_q;

    // R10: a detected edge lasts a single cycle
    a_r10_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      edge_w[g] |=> !edge_w[g]);
  end

  always_comb begin
    sel_w = '0;
    unique case (phase_i)
      PH_DIN_SYNC:  sel_w[STB_DACK] = 1'b1;
      PH_DIN_ASYNC: if (role_target_i) sel_w[STB_DACK] = 1'b1;
                    else               sel_w[STB_ACK]  = 1'b1;
      PH_DOUT:      if (role_target_i) sel_w[STB_REQ]  = 1'b1;
                    else               sel_w[STB_DACK] = 1'b1;
      default:      sel_w = '0;
    endcase
  end

  assign dec_pulse_o = |(sel_w & edge_w);

  // R9: exactly one source or none is routed to the counter
  a_r9_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_w));
endmodule

// File: rtl/xfer_start_regs.sv
module xfer_start_regs
  import xfer_count_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              wide_en_i,
  input  logic              nop_i,
  input  logic              load_i,
  output logic [CNT_W-1:0]  start_o,
  output logic              id_vis_o,
  output logic              wr_err_o
);
  logic [NUM_BYTES-1:0] byte_hit_w;
  logic                 count_hit_w, accept_w;
  logic                 armed_q, armed_d;
  logic                 err_q, err_d;
  logic                 id_vis_q, id_vis_d;
  logic [BYTE_W-1:0]    start_b [NUM_BYTES];

  always_comb begin
    byte_hit_w[0] = (addr_i == ADDR_W'(ADDR_LO));
    byte_hit_w[1] = (addr_i == ADDR_W'(ADDR_MID));
    byte_hit_w[2] = (addr_i == ADDR_W'(ADDR_HI)) && wide_en_i;
    count_hit_w   = wr_i && (|byte_hit_w);
    accept_w      = count_hit_w && armed_q;
  end

  always_comb begin
    armed_d  = load_i ? 1'b0 : (nop_i ? 1'b1 : armed_q);
    err_d    = err_q | (count_hit_w & ~armed_q);
    id_vis_d = id_vis_q & ~(accept_w & byte_hit_w[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      err_q    <= 1'b0;
      id_vis_q <= 1'b1;
    end else begin
      armed_q  <= armed_d;
      err_q    <= err_d;
      id_vis_q <= id_vis_d;
    end
  end

  // start bytes deliberately have no reset
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (accept_w && byte_hit_w[b]) start_b[b] <= wdata_i;
    end
    assign start_o[b*BYTE_W +: BYTE_W] = start_b[b];
  end

  assign id_vis_o = id_vis_q;
  assign wr_err_o = err_q;

  // R8: unarmed writes leave the start value alone and raise the flag
  a_r8_drop_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (count_hit_w && !armed_q) |=> ($stable(start_o) && err_q));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R7: the identification code never comes back without a reset
  a_r7_id_once: assert property (@(posedge clk) disable iff (!rst_n)
    !id_vis_q |=> !id_vis_q);
endmodule

// File: rtl/xfer_cur_counter.sv
module xfer_cur_counter
  import xfer_count_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             wide_en_i,
  input  logic             dec_i,
  input  logic             word_i,
  input  logic             status_rd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] MAX_WIDE   = CW'(1) << CNT_W;
  localparam logic [CW-1:0] MAX_NARROW = CW'(1) << NARROW_W;

  logic [CW-1:0] cnt_q, cnt_d, load_val_w, step_w;
  logic          tc_q, tc_d, reach_zero_w;

  always_comb begin
    if (wide_en_i)
      load_val_w = (start_i == '0) ? MAX_WIDE : {1'b0, start_i};
    else
      load_val_w = (start_i[NARROW_W-1:0] == '0) ? MAX_NARROW
                 : {{(CW-NARROW_W){1'b0}}, start_i[NARROW_W-1:0]};
    step_w       = {{(CW-2){1'b0}}, word_i, ~word_i};
    reach_zero_w = !load_i && dec_i && (cnt_q != '0) && (cnt_q <= step_w);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_w;
    else if (dec_i && (cnt_q != '0))
      cnt_d = (cnt_q > step_w) ? (cnt_q - step_w) : '0;
  end

  always_comb begin
    if (load_i)            tc_d = 1'b0;
    else if (reach_zero_w) tc_d = 1'b1;
    else if (status_rd_i)  tc_d = 1'b0;
    else                   tc_d = tc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
    end
  end

  assign cnt_o = cnt_q[CNT_W-1:0];
  assign tc_o  = tc_q;

  // R4: no wrap below zero and no growth without a load
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
  a_r4_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (cnt_q <= $past(cnt_q)));
  // R3: a load never leaves a zero count
  a_r3_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q != '0));
  // R5: arriving at zero raises terminal count; a load clears it
  a_r5_tc_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && $past(cnt_q) != '0 && !$past(load_i)) |-> tc_q);
  a_r5_tc_clear_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !tc_q);
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
  import xfer_count_pkg::*;
#(
  parameter int          ADDR_W      = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  ID_CODE     = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              wide_en,
  input  logic              cmd_dma_nop,
  input  logic              cmd_dma_load,
  input  logic              role_target,
  input  logic [1:0]        xfer_phase,
  input  logic              word_xfer,
  input  logic              dack_in,
  input  logic              req_in,
  input  logic              ack_in,
  input  logic              status_rd,
  output logic              term_count,
  output logic              wr_err
);
  logic [CNT_W-1:0] start_w, cnt_w;
  logic             id_vis_w, dec_w;

  xfer_strobe_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk           (clk),
    .rst_n         (rst_n),
    .role_target_i (role_target),
    .phase_i       (xfer_phase_e'(xfer_phase)),
    .dack_i        (dack_in),
    .req_i         (req_in),
    .ack_i         (ack_in),
    .dec_pulse_o   (dec_w)
  );

  xfer_start_regs #(.ADDR_W(ADDR_W)) u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr),
    .addr_i    (reg_addr),
    .wdata_i   (reg_wdata),
    .wide_en_i (wide_en),
    .nop_i     (cmd_dma_nop),
    .load_i    (cmd_dma_load),
    .start_o   (start_w),
    .id_vis_o  (id_vis_w),
    .wr_err_o  (wr_err)
  );

  xfer_cur_counter u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (cmd_dma_load),
    .start_i     (start_w),
    .wide_en_i   (wide_en),
    .dec_i       (dec_w),
    .word_i      (word_xfer),
    .status_rd_i (status_rd),
    .cnt_o       (cnt_w),
    .tc_o        (term_count)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == ADDR_W'(ADDR_LO))
        reg_rdata = cnt_w[7:0];
      else if (reg_addr == ADDR_W'(ADDR_MID))
        reg_rdata = cnt_w[15:8];
      else if (reg_addr == ADDR_W'(ADDR_HI))
        reg_rdata = id_vis_w ? ID_CODE : (wide_en ? cnt_w[23:16] : 8'h00);
    end
  end

  // R1: the read bus stays quiet without a read strobe
  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == 8'h00));
endmodule

// File: tb/xfer_count_unit_tb_top.sv
module xfer_count_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       wide_en, cmd_dma_nop, cmd_dma_load, role_target;
  logic [1:0] xfer_phase;
  logic       word_xfer, dack_in, req_in, ack_in, status_rd;
  logic       term_count, wr_err;

  localparam logic [7:0] ID = 8'hA5;
  localparam int S_DACK = 0, S_REQ = 1, S_ACK = 2;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  xfer_count_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wide_en(wide_en), .cmd_dma_nop(cmd_dma_nop), .cmd_dma_load(cmd_dma_load),
    .role_target(role_target), .xfer_phase(xfer_phase), .word_xfer(word_xfer),
    .dack_in(dack_in), .req_in(req_in), .ack_in(ack_in), .status_rd(status_rd),
    .term_count(term_count), .wr_err(wr_err)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte per read cycle
  always @(posedge clk) begin
    #1;
    if (reg_rd) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: unexpected read, actual %02h expected none", reg_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic nop();
    @(negedge clk); cmd_dma_nop = 1'b1;
    @(negedge clk); cmd_dma_nop = 1'b0;
  endtask

  task automatic load();
    @(negedge clk); cmd_dma_load = 1'b1;
    @(negedge clk); cmd_dma_load = 1'b0;
  endtask

  task automatic strobe(int which, logic w, int hold);
    @(negedge clk);
    word_xfer = w;
    case (which)
      S_DACK:  dack_in = 1'b1;
      S_REQ:   req_in  = 1'b1;
      default: ack_in  = 1'b1;
    endcase
    cyc(hold);
    dack_in = 1'b0; req_in = 1'b0; ack_in = 1'b0;
    cyc(4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    wide_en = 1; cmd_dma_nop = 0; cmd_dma_load = 0; role_target = 1;
    xfer_phase = 2'd3; word_xfer = 0; dack_in = 0; req_in = 0; ack_in = 0;
    status_rd = 0;
    do_reset();

    chk_bit("reset tc R5", term_count, 1'b0);
    chk_bit("reset err R8", wr_err, 1'b0);
    rd(4'h0, 8'h00, "reset lo R1");
    rd(4'h1, 8'h00, "reset mid R1");
    rd(4'hE, ID,    "id after reset R7");
    rd(4'h3, 8'h00, "unmapped R1");

    wr(4'h0, 8'h55);
    chk_bit("unarmed write flags R8", wr_err, 1'b1);

    nop();
    wr(4'h0, 8'h05); wr(4'h1, 8'h00);
    rd(4'hE, ID, "id kept R7");
    wr(4'hE, 8'h01);
    rd(4'hE, 8'h00, "id gone R7");
    load();
    rd(4'h0, 8'h05, "load lo R1 R3");
    rd(4'h1, 8'h00, "load mid R1");
    rd(4'hE, 8'h01, "load hi R1");

    role_target = 1; xfer_phase = 2'd0;
    strobe(S_DACK, 0, 3); rd(4'h0, 8'h04, "tgt din dack byte R4 R9");
    strobe(S_DACK, 1, 3); rd(4'h0, 8'h02, "tgt din dack word R4");
    strobe(S_DACK, 0, 10); rd(4'h0, 8'h01, "held strobe once R10");
    strobe(S_REQ, 0, 3);  rd(4'h0, 8'h01, "tgt din req ignored R9");
    strobe(S_ACK, 0, 3);  rd(4'h0, 8'h01, "tgt din ack ignored R9");
    xfer_phase = 2'd1;
    strobe(S_ACK, 0, 3);  rd(4'h0, 8'h01, "tgt async ack ignored R9");
    xfer_phase = 2'd2;
    strobe(S_REQ, 0, 3);  rd(4'h0, 8'h00, "tgt dout req R9");
    rd(4'hE, 8'h01, "borrow into hi R4");
    strobe(S_DACK, 0, 3); rd(4'h1, 8'h00, "tgt dout dack ignored R9");
    xfer_phase = 2'd3;
    strobe(S_DACK, 0, 3); rd(4'hE, 8'h01, "idle ignored R9");

    nop();
    wr(4'h0, 8'h03); wr(4'h1, 8'h00); wr(4'hE, 8'h00);
    load();
    role_target = 0; xfer_phase = 2'd1;
    strobe(S_ACK, 0, 3);  rd(4'h0, 8'h02, "ini async ack R9");
    strobe(S_DACK, 0, 3); rd(4'h0, 8'h02, "ini async dack ignored R9");
    xfer_phase = 2'd0;
    strobe(S_DACK, 0, 3); rd(4'h0, 8'h01, "ini sync dack R9");
    strobe(S_ACK, 0, 3);  rd(4'h0, 8'h01, "ini sync ack ignored R9");
    xfer_phase = 2'd2;
    chk_bit("tc low before zero R5", term_count, 1'b0);
    strobe(S_DACK, 1, 3); rd(4'h0, 8'h00, "word saturates R4");
    chk_bit("tc at zero R5", term_count, 1'b1);
    strobe(S_DACK, 0, 3);
    rd(4'hE, 8'h00, "no wrap hi R4");
    rd(4'h1, 8'h00, "no wrap mid R4");
    chk_bit("tc held R5", term_count, 1'b1);
    @(negedge clk); status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
    chk_bit("status read clears R5", term_count, 1'b0);

    nop(); wr(4'h0, 8'h01); load();
    strobe(S_DACK, 0, 3);
    chk_bit("tc set again R5", term_count, 1'b1);
    load();
    chk_bit("load clears tc R5", term_count, 1'b0);
    rd(4'h0, 8'h01, "reload R3");

    nop(); wr(4'h0, 8'h00); load();
    rd(4'h0, 8'h00, "max wide lo R3");
    rd(4'hE, 8'h00, "max wide hi R3");
    strobe(S_DACK, 0, 3);
    rd(4'h0, 8'hFF, "max wide dec lo R3");
    rd(4'h1, 8'hFF, "max wide dec mid R3");
    rd(4'hE, 8'hFF, "max wide dec hi R3");

    wide_en = 0; load();
    strobe(S_DACK, 0, 3);
    rd(4'h0, 8'hFF, "max narrow lo R2 R3");
    rd(4'h1, 8'hFF, "max narrow mid R2");
    rd(4'hE, 8'h00, "narrow hi reads zero R2");

    nop(); wr(4'h0, 8'h02); wr(4'hE, 8'h07);
    wide_en = 1; load();
    rd(4'hE, 8'h00, "narrow hi write ignored R2");
    rd(4'h0, 8'h02, "narrow start lo R2");

    do_reset();
    chk_bit("err cleared by reset R8", wr_err, 1'b0);
    chk_bit("tc cleared by reset R5", term_count, 1'b0);
    rd(4'h0, 8'h00, "count reset R6");
    rd(4'hE, ID, "id back after reset R7");
    load();
    rd(4'h0, 8'h02, "start kept through reset R6");
    wr(4'h0, 8'h09);
    chk_bit("load disarms R8", wr_err, 1'b1);
    load();
    rd(4'h0, 8'h02, "dropped write R8");

    cyc(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule